// File: doc/BRIEF.md
# Transmit Timestamp Collection Queue

This block collects the transmit timestamps that an Ethernet MAC reports for outgoing frames. On each strobe it takes a timestamp (seconds LSBs and reference-clock cycles), the identifier of the frame the timestamp belongs to, and the identifier of the port that sent it. It stores all three as one descriptor in a single queue shared by every port. The port field is kept even on a single-port system, so the descriptor layout is the same as on a multi-port switch.

Host software drains the queue through a small bank of registers on a Wishbone slave port. The status word shows the fill count and a sticky overflow flag. Three data words show the oldest descriptor, and reading the last of them removes that descriptor. An interrupt line stays high for as long as the queue holds anything.

Top module: `txts_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `irq_o` is low and the status word reads 0.
- R2: A strobe on `ts_stb_i` stores one descriptor. Descriptors are read back oldest first, whatever their port. Word 1 holds the seconds. Word 2 holds the cycles in bits [27:0]. Word 3 holds the frame ID in [15:0], the port ID in [20:16] and a valid flag in bit 31.
- R3: A read of word 3 removes the oldest descriptor. Reads of words 0, 1 and 2 remove nothing.
- R4: While the queue is empty, reads of words 1, 2 and 3 return 0, so the valid flag is clear, and nothing is removed.
- R5: `irq_o` is high exactly while the fill count is non-zero. It rises on the clock edge that stores the first descriptor.
- R6: Status word 0 has bit 0 set when the queue is not empty, bit 1 as the overflow flag, and the fill count in bits [12:8].
- R7: With 16 descriptors held, a new strobe is dropped, the overflow flag is set, and the stored contents are unchanged.
- R8: Writing word 0 with bit 1 set clears the overflow flag. A write with bit 1 clear leaves the flag as it is. A drop in the same cycle as a clearing write leaves the flag set.
- R9: A strobe and a removing read in the same cycle, with the queue neither empty nor full, both take effect and leave the count unchanged.
- R10: Each request is acknowledged exactly one cycle after it is presented, with a one-cycle `wb_ack_o`. Writes to words 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_stb_i | input | 1 | Timestamp valid strobe |
| ts_sec_i | input | 32 | Seconds LSBs of the timestamp |
| ts_cyc_i | input | 28 | Reference-clock cycles of the timestamp |
| ts_fid_i | input | 16 | Frame identifier |
| ts_pid_i | input | 5 | Port identifier |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 2 | Word select |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| irq_o | output | 1 | Interrupt, high while the queue is non-empty |

## Verification
The assertions assume a bus master that holds `wb_cyc_i` and `wb_stb_i` until it sees the acknowledge and then drops them. They also assume all inputs are synchronous to `clk`. The bench drives every request for exactly one cycle at the falling edge and releases it on the falling edge where the acknowledge is seen. Strobes are single-cycle pulses, some placed in the same cycle as a removing read or a flag-clearing write, so that the simultaneous cases meet the sticky and counting rules without breaking the bus assumption.

// File: rtl/txts_pkg.sv
// Shared register selection and bit placement for the timestamp queue.
package txts_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_SECONDS = 2'd1,
        SEL_CYCLES  = 2'd2,
        SEL_IDENT   = 2'd3
    } sel_e;

    localparam int STAT_NE_BIT     = 0;
    localparam int STAT_OVF_BIT    = 1;
    localparam int STAT_CNT_LSB    = 8;
    localparam int IDENT_VALID_BIT = 31;
endpackage

// File: rtl/txts_fifo.sv
// Descriptor store: circular buffer with a fill counter.
// Assumes: a push is accepted only below DEPTH entries; a pop is honoured only
// when non-empty; the head output is meaningful only while count is non-zero.
module txts_fifo #(
    parameter int W     = 81,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [W-1:0]  din,
    input  logic          pop_req,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push_req && (count < CW'(DEPTH));
    assign pop_ok  = pop_req && (count != '0);
    assign drop    = push_req && !push_ok;
    assign head    = mem[rd_ptr];

    // Pointer and fill-count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/txts_regs.sv
// Register front end: single-cycle acknowledge, read mux, pop request and the
// sticky overflow flag. Assumes the master drops its strobe after the ack.
module txts_regs
    import txts_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int CYC_W = 28,
    parameter int FID_W = 16,
    parameter int PID_W = 5,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [1:0]       wb_adr_i,
    input  logic             clr_bit_i,
    input  logic [SEC_W-1:0] head_sec,
    input  logic [CYC_W-1:0] head_cyc,
    input  logic [FID_W-1:0] head_fid,
    input  logic [PID_W-1:0] head_pid,
    input  logic [CW-1:0]    count,
    input  logic             drop,
    output logic             pop_req,
    output logic             ovf,
    output logic [31:0]      wb_dat_o,
    output logic             wb_ack_o
);
    logic        req, nonempty;
    sel_e        sel;
    logic [31:0] rd_word;

    assign req      = wb_cyc_i && wb_stb_i && !wb_ack_o;
    assign sel      = sel_e'(wb_adr_i);
    assign nonempty = (count != '0);
    assign pop_req  = req && !wb_we_i && (sel == SEL_IDENT);

    // Read data selection for the addressed word
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_STATUS: begin
                rd_word[STAT_NE_BIT]            = nonempty;
                rd_word[STAT_OVF_BIT]           = ovf;
                rd_word[STAT_CNT_LSB +: CW]     = count;
            end
            SEL_SECONDS: if (nonempty) rd_word = 32'(head_sec);
            SEL_CYCLES:  if (nonempty) rd_word = 32'(head_cyc);
            SEL_IDENT: if (nonempty) begin
                rd_word[FID_W-1:0]             = head_fid;
                rd_word[FID_W +: PID_W]        = head_pid;
                rd_word[IDENT_VALID_BIT]       = 1'b1;
            end
            default: rd_word = '0;
        endcase
    end

    // Acknowledge and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack_o <= req;
            if (req) wb_dat_o <= wb_we_i ? '0 : rd_word;
        end
    end

    // Sticky overflow: a drop wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
        else if (req && wb_we_i && (sel == SEL_STATUS) && clr_bit_i)
            ovf <= 1'b0;
    end
endmodule

// File: rtl/txts_queue.sv
// Top: packs incoming timestamp descriptors into the shared store and exposes
// them through the register front end; irq follows the non-empty state.
module txts_queue
    import txts_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int CYC_W = 28,
    parameter int FID_W = 16,
    parameter int PID_W = 5,
    parameter int DEPTH = 16,
    localparam int EW   = SEC_W + CYC_W + FID_W + PID_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_stb_i,
    input  logic [SEC_W-1:0] ts_sec_i,
    input  logic [CYC_W-1:0] ts_cyc_i,
    input  logic [FID_W-1:0] ts_fid_i,
    input  logic [PID_W-1:0] ts_pid_i,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [1:0]       wb_adr_i,
    input  logic [31:0]      wb_dat_i,
    output logic [31:0]      wb_dat_o,
    output logic             wb_ack_o,
    output logic             irq_o
);
    logic [EW-1:0] head;
    logic [CW-1:0] count;
    logic          drop, pop_req, ovf;
    logic          unused_dat;

    assign unused_dat = ^{wb_dat_i[31:STAT_OVF_BIT+1], wb_dat_i[STAT_OVF_BIT-1:0]};
    assign irq_o      = (count != '0);

    txts_fifo #(.W(EW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (ts_stb_i),
        .din      ({ts_pid_i, ts_fid_i, ts_cyc_i, ts_sec_i}),
        .pop_req  (pop_req),
        .head     (head),
        .count    (count),
        .drop     (drop)
    );

    txts_regs #(
        .SEC_W(SEC_W), .CYC_W(CYC_W), .FID_W(FID_W), .PID_W(PID_W), .CW(CW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_cyc_i  (wb_cyc_i),
        .wb_stb_i  (wb_stb_i),
        .wb_we_i   (wb_we_i),
        .wb_adr_i  (wb_adr_i),
        .clr_bit_i (wb_dat_i[STAT_OVF_BIT]),
        .head_sec  (head[SEC_W-1:0]),
        .head_cyc  (head[SEC_W +: CYC_W]),
        .head_fid  (head[SEC_W+CYC_W +: FID_W]),
        .head_pid  (head[SEC_W+CYC_W+FID_W +: PID_W]),
        .count     (count),
        .drop      (drop),
        .pop_req   (pop_req),
        .ovf       (ovf),
        .wb_dat_o  (wb_dat_o),
        .wb_ack_o  (wb_ack_o)
    );
endmodule

// File: rtl/txts_queue_chk.sv
// Checker for txts_queue: bus handshake, bound on fill, sticky overflow and irq.
// Assumes the master keeps its strobe until the acknowledge.
module txts_queue_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ts_stb_i,
    input logic          wb_cyc_i,
    input logic          wb_stb_i,
    input logic          wb_we_i,
    input logic [1:0]    wb_adr_i,
    input logic [31:0]   wb_dat_i,
    input logic          wb_ack_o,
    input logic          irq_o,
    input logic [CW-1:0] count,
    input logic          ovf
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o); // R10
    AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_stb_i && count == CW'(DEPTH)) |=> ovf); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wb_cyc_i && wb_stb_i && !wb_ack_o && wb_we_i
                  && wb_adr_i == 2'd0 && wb_dat_i[1])) |=> ovf); // R8
    AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_stb_i && count == '0) |=> irq_o); // R5
endmodule

bind txts_queue txts_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts_stb_i (ts_stb_i),
    .wb_cyc_i (wb_cyc_i),
    .wb_stb_i (wb_stb_i),
    .wb_we_i  (wb_we_i),
    .wb_adr_i (wb_adr_i),
    .wb_dat_i (wb_dat_i),
    .wb_ack_o (wb_ack_o),
    .irq_o    (irq_o),
    .count    (count),
    .ovf      (ovf)
);

// File: tb/txts_queue_tb.sv
// Bench for txts_queue: behavioural queue model compared on every clock,
// plus directed checks per requirement.
module txts_queue_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_stb_i = 1'b0;
    logic [31:0] ts_sec_i = '0;
    logic [27:0] ts_cyc_i = '0;
    logic [15:0] ts_fid_i = '0;
    logic [4:0]  ts_pid_i = '0;
    logic        wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
    logic [1:0]  wb_adr_i = '0;
    logic [31:0] wb_dat_i = '0;
    logic [31:0] wb_dat_o;
    logic        wb_ack_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    txts_queue u_dut (
        .clk(clk), .rst_n(rst_n), .ts_stb_i(ts_stb_i), .ts_sec_i(ts_sec_i),
        .ts_cyc_i(ts_cyc_i), .ts_fid_i(ts_fid_i), .ts_pid_i(ts_pid_i),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
        .wb_ack_o(wb_ack_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [80:0] mq[$];
    logic        m_ovf = 1'b0, m_ack = 1'b0, m_we = 1'b0;
    logic [31:0] m_dat = '0;
    string       m_tag = "R2";

    function automatic logic [31:0] model_word(input logic [1:0] a);
        logic [80:0] e;
        if (a == 2'd0)
            return {19'd0, 5'(mq.size()), 6'd0, m_ovf, mq.size() != 0};
        if (mq.size() == 0) return '0;
        e = mq[0];
        case (a)
            2'd1:    return e[31:0];
            2'd2:    return {4'd0, e[59:32]};
            default: return {1'b1, 10'd0, e[80:76], e[75:60]};
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic req;
        int   pre;
        if (!rst_n) begin
            mq.delete();
            m_ovf = 1'b0;
            m_ack = 1'b0;
            m_dat = '0;
        end else begin
            req = wb_cyc_i && wb_stb_i && !m_ack;
            pre = mq.size();
            if (req) begin
                m_we = wb_we_i;
                if (!wb_we_i) begin
                    m_dat = model_word(wb_adr_i);
                    m_tag = (wb_adr_i == 2'd0) ? "R6" :
                            (pre == 0)         ? "R4" :
                            (wb_adr_i == 2'd3) ? "R3" : "R2";
                end
            end
            if (req && wb_we_i && wb_adr_i == 2'd0 && wb_dat_i[1]) m_ovf = 1'b0;
            if (req && !wb_we_i && wb_adr_i == 2'd3 && pre > 0) void'(mq.pop_front());
            if (ts_stb_i) begin
                if (pre < DEPTH) mq.push_back({ts_pid_i, ts_fid_i, ts_cyc_i, ts_sec_i});
                else m_ovf = 1'b1;
            end
            m_ack = req;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_o == (mq.size() != 0), "R5 irq", 32'(irq_o), 32'(mq.size() != 0));
            chk(wb_ack_o == m_ack, "R10 ack", 32'(wb_ack_o), 32'(m_ack));
            if (m_ack && !m_we && wb_ack_o)
                chk(wb_dat_o == m_dat, m_tag, wb_dat_o, m_dat);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_ts(input logic [31:0] s, input logic [27:0] c,
                          input logic [15:0] f, input logic [4:0] p);
        ts_stb_i = 1'b1; ts_sec_i = s; ts_cyc_i = c; ts_fid_i = f; ts_pid_i = p;
    endtask

    task automatic push(input logic [31:0] s, input logic [27:0] c,
                        input logic [15:0] f, input logic [4:0] p);
        @(negedge clk);
        set_ts(s, c, f, p);
        @(negedge clk);
        ts_stb_i = 1'b0;
    endtask

    task automatic bus(input logic we, input logic [1:0] a, input logic [31:0] wd,
                       input bit with_ts, input logic [31:0] s,
                       output logic [31:0] rd);
        @(negedge clk);
        wb_cyc_i = 1'b1; wb_stb_i = 1'b1; wb_we_i = we; wb_adr_i = a; wb_dat_i = wd;
        if (with_ts) set_ts(s, 28'h55, 16'hBEEF, 5'd9);
        @(negedge clk);
        rd = wb_dat_o;
        wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0; ts_stb_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus(1'b0, a, '0, 1'b0, '0, d);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        logic [31:0] d;
        bus(1'b1, a, v, 1'b0, '0, d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
        rd(2'd0, d);
        chk(d == 0, "R1 status", d, 0);

        // R2 three descriptors from different ports
        push(32'h1000_0001, 28'h0ABCDEF, 16'h0101, 5'd0);
        push(32'h2000_0002, 28'h0000123, 16'h0202, 5'd3);
        push(32'h3000_0003, 28'hFFFFFFF, 16'hFFFF, 5'd31);
        chk(irq_o == 1'b1, "R5 irq high", 32'(irq_o), 1);

        // R3 reads of seconds do not remove
        rd(2'd1, d);
        rd(2'd1, d);
        rd(2'd0, d);
        chk(d[12:8] == 5'd3, "R3 count after non-removing reads", 32'(d[12:8]), 3);
        rd(2'd2, d);
        chk(d == 32'h0ABCDEF, "R2 cycles word", d, 32'h0ABCDEF);
        rd(2'd3, d);
        chk(d == 32'h8000_0101, "R2 ident word", d, 32'h8000_0101);
        for (int i = 0; i < 2; i++) begin
            rd(2'd1, d);
            rd(2'd2, d);
            rd(2'd3, d);
        end
        chk(d == {1'b1, 10'd0, 5'd31, 16'hFFFF}, "R2 port 31 order", d,
            {1'b1, 10'd0, 5'd31, 16'hFFFF});

        // R4 empty reads
        rd(2'd1, d);
        chk(d == 0, "R4 empty seconds", d, 0);
        rd(2'd3, d);
        chk(d == 0, "R4 empty ident", d, 0);
        chk(irq_o == 1'b0, "R5 irq low", 32'(irq_o), 0);

        // R10 writes to data words ignored
        push(32'hCAFE_0000, 28'h1, 16'h1, 5'd1);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, d);
        chk(d == 32'hCAFE_0000, "R10 write ignored", d, 32'hCAFE_0000);
        rd(2'd3, d);

        // R7 fill beyond depth
        for (int i = 0; i < DEPTH + 4; i++)
            push(32'(i), 28'(i), 16'(i), 5'(i));
        rd(2'd0, d);
        chk(d[12:8] == 5'd16 && d[1], "R7 full with overflow", d, 32'h1003);

        // R8 clear rules
        wr(2'd0, 32'h1);
        rd(2'd0, d);
        chk(d[1] == 1'b1, "R8 write without bit1 keeps flag", 32'(d[1]), 1);
        bus(1'b1, 2'd0, 32'h2, 1'b1, 32'hDEAD, d);
        rd(2'd0, d);
        chk(d[1] == 1'b1, "R8 drop beats clear", 32'(d[1]), 1);
        wr(2'd0, 32'h2);
        rd(2'd0, d);
        chk(d[1] == 1'b0, "R8 clear", 32'(d[1]), 0);

        // R7 oldest survives, dropped ones never appear
        rd(2'd1, d);
        chk(d == 0, "R7 oldest kept", d, 0);
        for (int i = 0; i < DEPTH; i++) rd(2'd3, d);
        chk(d == {1'b1, 10'd0, 5'd15, 16'd15}, "R7 last kept", d,
            {1'b1, 10'd0, 5'd15, 16'd15});

        // R9 simultaneous store and removal
        push(32'hA1, 28'hA1, 16'hA1, 5'd1);
        push(32'hA2, 28'hA2, 16'hA2, 5'd2);
        bus(1'b0, 2'd3, '0, 1'b1, 32'hA3, d);
        rd(2'd0, d);
        chk(d[12:8] == 5'd2, "R9 count kept", 32'(d[12:8]), 2);
        rd(2'd3, d);
        rd(2'd1, d);
        chk(d == 32'hA3, "R9 concurrent entry stored", d, 32'hA3);
        rd(2'd3, d);
        chk(irq_o == 1'b0, "R5 drained", 32'(irq_o), 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule